// File: doc/BRIEF.md
# Signed Fixed-Point Divider with Overflow Trap

This block carries out signed fixed-point division one bit per clock. In word mode it divides a 64-bit dividend by a 32-bit divisor. The dividend is taken from a pair of registers, or from one register sign-extended when the destination number is odd. In halfword mode it divides a 32-bit register by the signed low 16 bits of the divisor input. Division truncates toward zero, and any nonzero remainder has the sign of the dividend.

The block receives the operands already fetched, the current 4-bit condition code and the arithmetic trap mask. When a division finishes it presents register write strobes and data, the new condition code, and a trap request with its vector, all for one cycle. If the quotient does not fit in 32 signed bits, or the divisor is zero, nothing is written back. The other condition bits keep their old values and only the overflow bit is set. The surrounding sequencer performs the writes and takes the trap.

Top module: `fxdiv_unit`

## Requirements
- R1: After reset, and while no start has been accepted, `done`, `wr_r_en`, `wr_r1_en` and `trap_req` are 0.
- R2: Word mode (`half_mode`=0) with `odd_dst`=0 divides the 64-bit signed value {`reg_r`,`reg_r1`} by the 32-bit signed `divisor`. The quotient truncates toward zero and the remainder has the dividend's sign. The remainder appears on `wr_r_data` with `wr_r_en`=1, and the quotient on `wr_r1_data` with `wr_r1_en`=1.
- R3: Word mode with `odd_dst`=1 divides `reg_r`, sign-extended to 64 bits, by `divisor`. The quotient appears on `wr_r_data` with `wr_r_en`=1. `wr_r1_en` stays 0 and the remainder is dropped.
- R4: Halfword mode (`half_mode`=1) divides the signed `reg_r` by `divisor[15:0]` taken as a signed 16-bit value. The quotient appears on `wr_r_data` with `wr_r_en`=1. `wr_r1_en` is 0, and `reg_r1`, `divisor[31:16]` and `odd_dst` have no effect.
- R5: Overflow occurs when the true quotient lies outside [-2^31, 2^31-1] or the divisor is zero. On overflow both write enables are 0 and `cc_out` = {`cc_in[3]`, 1, `cc_in[1]`, `cc_in[0]`}.
- R6: Without overflow, `cc_out` = {`cc_in[3]`, 0, quotient>0, quotient<0}. Bit 2 is the overflow bit, bit 1 flags a positive quotient and bit 0 a negative one.
- R7: `trap_req` is 1 in the done cycle exactly when overflow occurs and `trap_mask`=1. In that case `trap_vec` = 8'h43.
- R8: `done` is a one-cycle pulse. It is seen after the 65th rising edge (word mode) or the 33rd rising edge (halfword mode) that follows the edge sampling `start`. Write enables are 1 only while `done` is 1.
- R9: `start` and operand changes are ignored while a division is in progress. A `start` given in the cycle where `done` is 1 is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division using the present inputs |
| half_mode | input | 1 | 1: halfword divide, 0: word divide |
| odd_dst | input | 1 | Destination register number is odd |
| reg_r | input | 32 | Contents of the destination register |
| reg_r1 | input | 32 | Contents of the following register (low dividend word) |
| divisor | input | 32 | Effective divisor operand |
| cc_in | input | 4 | Current condition code, bit 3 first flag |
| trap_mask | input | 1 | Arithmetic trap enable |
| done | output | 1 | One-cycle completion strobe |
| wr_r_en | output | 1 | Write strobe for the destination register |
| wr_r_data | output | 32 | Data for the destination register |
| wr_r1_en | output | 1 | Write strobe for the following register |
| wr_r1_data | output | 32 | Data for the following register |
| cc_out | output | 4 | New condition code, valid with done |
| trap_req | output | 1 | Overflow trap request |
| trap_vec | output | 8 | Trap vector, 8'h43 when trap_req is 1 |

## Verification
Completion of one division and acceptance of the next can happen in the same cycle. The bench provokes this by raising `start` with new operands in the very cycle it sees `done`, without an idle gap. It then judges the first result as sampled and checks that the second division returns its own correct quotient and flags after the full latency. A related check pulses `start` with scrambled operands in the middle of a division and requires the original result to come out unchanged.

// File: rtl/fxdiv_pkg.sv
package fxdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } fsm_e;
endpackage

// File: rtl/fxdiv_prep.sv
// Operand formation: builds signed dividend/divisor per mode, then magnitudes.
module fxdiv_prep #(
  parameter int W  = 32,
  parameter int HW = 16
) (
  input  logic           half_mode,
  input  logic           odd_dst,
  input  logic [W-1:0]   reg_a,
  input  logic [W-1:0]   reg_b,
  input  logic [W-1:0]   dvs_in,
  output logic [2*W-1:0] dvd_mag,
  output logic [W-1:0]   dvs_mag,
  output logic           dvd_neg,
  output logic           dvs_neg,
  output logic           dvs_zero
);
  localparam int DW = 2 * W;

  logic [DW-1:0] dvd_s;
  logic [DW-1:0] mag_d;
  logic [W-1:0]  dvs_s;

  always_comb begin
    if (half_mode) begin
      dvd_s = {{W{reg_a[W-1]}}, reg_a};
      dvs_s = {{(W-HW){dvs_in[HW-1]}}, dvs_in[HW-1:0]};
    end else if (odd_dst) begin
      dvd_s = {{W{reg_a[W-1]}}, reg_a};
      dvs_s = dvs_in;
    end else begin
      dvd_s = {reg_a, reg_b};
      dvs_s = dvs_in;
    end
    dvd_neg  = dvd_s[DW-1];
    dvs_neg  = dvs_s[W-1];
    mag_d    = dvd_neg ? -dvd_s : dvd_s;
    // halfword magnitude fits W bits; move it to the top so W steps suffice
    dvd_mag  = half_mode ? (mag_d << W) : mag_d;
    dvs_mag  = dvs_neg ? -dvs_s : dvs_s;
    dvs_zero = (dvs_s == '0);
  end
endmodule

// File: rtl/fxdiv_core.sv
// Non-restoring magnitude division, one quotient bit per step.
module fxdiv_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [2*W-1:0] dvd_mag,
  input  logic [W-1:0]   dvs_mag,
  output logic [2*W-1:0] quo_mag,
  output logic [W-1:0]   rem_mag
);
  localparam int DW = 2 * W;
  localparam int PW = W + 2;

  logic [PW-1:0] pr;
  logic [DW-1:0] dq;
  logic [W-1:0]  dv;
  logic [PW-1:0] pr_sh;
  logic [PW-1:0] dext;
  logic [PW-1:0] nxt;

  always_comb begin
    pr_sh = {pr[W:0], dq[DW-1]};
    dext  = {2'b00, dv};
    nxt   = pr[PW-1] ? (pr_sh + dext) : (pr_sh - dext);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pr <= '0;
      dq <= '0;
      dv <= '0;
    end else if (load) begin
      pr <= '0;
      dq <= dvd_mag;
      dv <= dvs_mag;
    end else if (step) begin
      pr <= nxt;
      dq <= {dq[DW-2:0], ~nxt[PW-1]};
    end
  end

  assign quo_mag = dq;
  // deferred restore; the final remainder is below the divisor, so W bits hold it
  assign rem_mag = pr[W-1:0] + (pr[PW-1] ? dv : '0);
endmodule

// File: rtl/fxdiv_post.sv
// Sign fix-up, 32-bit range check and quotient classification.
module fxdiv_post #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] quo_mag,
  input  logic [W-1:0]   rem_mag,
  input  logic           dvd_neg,
  input  logic           dvs_neg,
  input  logic           dvs_zero,
  output logic           ovf,
  output logic [W-1:0]   quo,
  output logic [W-1:0]   rem,
  output logic           q_pos,
  output logic           q_neg
);
  localparam int DW = 2 * W;
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] q_lo;
  logic         neg_q;
  logic         too_big;

  always_comb begin
    q_lo    = quo_mag[W-1:0];
    neg_q   = dvd_neg ^ dvs_neg;
    too_big = neg_q ? (q_lo > NEG_LIM) : q_lo[W-1];
    ovf     = dvs_zero | (|quo_mag[DW-1:W]) | too_big;
    quo     = neg_q ? -q_lo : q_lo;
    rem     = dvd_neg ? -rem_mag : rem_mag;
    q_neg   = quo[W-1];
    q_pos   = ~quo[W-1] & (|quo);
  end
endmodule

// File: rtl/fxdiv_unit.sv
module fxdiv_unit #(
  parameter int                WORD_W   = 32,
  parameter int                HALF_W   = 16,
  parameter int                VEC_W    = 8,
  parameter logic [VEC_W-1:0]  TRAP_VEC = 8'h43
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              half_mode,
  input  logic              odd_dst,
  input  logic [WORD_W-1:0] reg_r,
  input  logic [WORD_W-1:0] reg_r1,
  input  logic [WORD_W-1:0] divisor,
  input  logic [3:0]        cc_in,
  input  logic              trap_mask,
  output logic              done,
  output logic              wr_r_en,
  output logic [WORD_W-1:0] wr_r_data,
  output logic              wr_r1_en,
  output logic [WORD_W-1:0] wr_r1_data,
  output logic [3:0]        cc_out,
  output logic              trap_req,
  output logic [VEC_W-1:0]  trap_vec
);
  import fxdiv_pkg::*;

  localparam int DW    = 2 * WORD_W;
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] WORD_STEPS = CNT_W'(DW);
  localparam logic [CNT_W-1:0] HALF_STEPS = CNT_W'(WORD_W);

  fsm_e             st;
  logic [CNT_W-1:0] cnt;
  logic             half_q, odd_q, mask_q;
  logic             dvd_neg_q, dvs_neg_q, zero_q;
  logic [2:0]       cc_keep;
  logic             accept;

  logic [DW-1:0]     dvd_mag, quo_mag;
  logic [WORD_W-1:0] dvs_mag, rem_mag, quo, rem;
  logic              dvd_neg, dvs_neg, dvs_zero;
  logic              ovf, q_pos, q_neg;

  assign accept = start && (st == ST_IDLE);

  fxdiv_prep #(.W(WORD_W), .HW(HALF_W)) u_prep (
    .half_mode (half_mode),
    .odd_dst   (odd_dst),
    .reg_a     (reg_r),
    .reg_b     (reg_r1),
    .dvs_in    (divisor),
    .dvd_mag   (dvd_mag),
    .dvs_mag   (dvs_mag),
    .dvd_neg   (dvd_neg),
    .dvs_neg   (dvs_neg),
    .dvs_zero  (dvs_zero)
  );

  fxdiv_core #(.W(WORD_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .step    (st == ST_RUN),
    .dvd_mag (dvd_mag),
    .dvs_mag (dvs_mag),
    .quo_mag (quo_mag),
    .rem_mag (rem_mag)
  );

  fxdiv_post #(.W(WORD_W)) u_post (
    .quo_mag  (quo_mag),
    .rem_mag  (rem_mag),
    .dvd_neg  (dvd_neg_q),
    .dvs_neg  (dvs_neg_q),
    .dvs_zero (zero_q),
    .ovf      (ovf),
    .quo      (quo),
    .rem      (rem),
    .q_pos    (q_pos),
    .q_neg    (q_neg)
  );

  // control and operand-context capture
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      half_q    <= 1'b0;
      odd_q     <= 1'b0;
      mask_q    <= 1'b0;
      dvd_neg_q <= 1'b0;
      dvs_neg_q <= 1'b0;
      zero_q    <= 1'b0;
      cc_keep   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          st        <= ST_RUN;
          cnt       <= half_mode ? HALF_STEPS : WORD_STEPS;
          half_q    <= half_mode;
          odd_q     <= odd_dst;
          mask_q    <= trap_mask;
          dvd_neg_q <= dvd_neg;
          dvs_neg_q <= dvs_neg;
          zero_q    <= dvs_zero;
          cc_keep   <= {cc_in[3], cc_in[1:0]};
        end
        ST_RUN: begin
          cnt <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) st <= ST_FIN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // registered result stage
  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      wr_r_en    <= 1'b0;
      wr_r_data  <= '0;
      wr_r1_en   <= 1'b0;
      wr_r1_data <= '0;
      cc_out     <= '0;
      trap_req   <= 1'b0;
      trap_vec   <= '0;
    end else begin
      done       <= 1'b0;
      wr_r_en    <= 1'b0;
      wr_r_data  <= '0;
      wr_r1_en   <= 1'b0;
      wr_r1_data <= '0;
      cc_out     <= '0;
      trap_req   <= 1'b0;
      trap_vec   <= '0;
      if (st == ST_FIN) begin
        done     <= 1'b1;
        trap_req <= ovf & mask_q;
        trap_vec <= (ovf & mask_q) ? TRAP_VEC : '0;
        if (ovf) begin
          cc_out <= {cc_keep[2], 1'b1, cc_keep[1:0]};
        end else begin
          cc_out  <= {cc_keep[2], 1'b0, q_pos, q_neg};
          wr_r_en <= 1'b1;
          if (half_q || odd_q) begin
            wr_r_data <= quo;
          end else begin
            wr_r_data  <= rem;
            wr_r1_en   <= 1'b1;
            wr_r1_data <= quo;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fxdiv_unit_chk.sv
module fxdiv_unit_chk #(
  parameter int               VEC_W    = 8,
  parameter logic [VEC_W-1:0] TRAP_VEC = 8'h43
) (
  input logic             clk,
  input logic             rst,
  input logic             done,
  input logic             wr_r_en,
  input logic             wr_r1_en,
  input logic [3:0]       cc_out,
  input logic             trap_req,
  input logic [VEC_W-1:0] trap_vec
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_WRITE_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    (wr_r_en || wr_r1_en) |-> done); // R8
  AST_OVF_BLOCKS_WRITES: assert property (@(posedge clk) disable iff (rst)
    (done && cc_out[2]) |-> !(wr_r_en || wr_r1_en)); // R5
  AST_NO_OVF_WRITES_R: assert property (@(posedge clk) disable iff (rst)
    (done && !cc_out[2]) |-> wr_r_en); // R2
  AST_PAIR_NEEDS_R: assert property (@(posedge clk) disable iff (rst)
    wr_r1_en |-> wr_r_en); // R2
  AST_CC_SIGN_EXCL: assert property (@(posedge clk) disable iff (rst)
    (done && !cc_out[2]) |-> !(cc_out[1] && cc_out[0])); // R6
  AST_TRAP_ON_OVF: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (done && cc_out[2])); // R7
  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (trap_vec == TRAP_VEC)); // R7
endmodule

bind fxdiv_unit fxdiv_unit_chk #(.VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .done     (done),
  .wr_r_en  (wr_r_en),
  .wr_r1_en (wr_r1_en),
  .cc_out   (cc_out),
  .trap_req (trap_req),
  .trap_vec (trap_vec)
);

// File: tb/fxdiv_unit_test.sv
module fxdiv_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        half_mode = 1'b0;
  logic        odd_dst = 1'b0;
  logic [31:0] reg_r = '0, reg_r1 = '0, divisor = '0;
  logic [3:0]  cc_in = '0;
  logic        trap_mask = 1'b0;
  logic        done, wr_r_en, wr_r1_en, trap_req;
  logic [31:0] wr_r_data, wr_r1_data;
  logic [3:0]  cc_out;
  logic [7:0]  trap_vec;

  int n_vec = 0;
  int n_bad = 0;

  typedef struct packed {
    logic        ovf;
    logic        wa;
    logic [31:0] da;
    logic        wb;
    logic [31:0] db;
    logic [3:0]  cc;
    logic        trap;
  } exp_t;

  always #(CLK_PERIOD/2) clk = ~clk;

  fxdiv_unit uut (
    .clk(clk), .rst(rst), .start(start), .half_mode(half_mode), .odd_dst(odd_dst),
    .reg_r(reg_r), .reg_r1(reg_r1), .divisor(divisor), .cc_in(cc_in),
    .trap_mask(trap_mask), .done(done), .wr_r_en(wr_r_en), .wr_r_data(wr_r_data),
    .wr_r1_en(wr_r1_en), .wr_r1_data(wr_r1_data), .cc_out(cc_out),
    .trap_req(trap_req), .trap_vec(trap_vec)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input bit hm, input bit od, input logic [31:0] ra,
                                 input logic [31:0] rb, input logic [31:0] dv,
                                 input logic [3:0] ci, input bit mk);
    exp_t   e;
    longint a, b, q, rm;
    bit     ov;
    if (hm) begin
      a = longint'($signed(ra));
      b = longint'($signed(dv[15:0]));
    end else if (od) begin
      a = longint'($signed(ra));
      b = longint'($signed(dv));
    end else begin
      a = longint'({ra, rb});
      b = longint'($signed(dv));
    end
    q  = 0;
    rm = 0;
    ov = (b == 0) || (a == longint'({1'b1, 63'd0}) && b == -1);
    if (!ov) begin
      q  = a / b;
      rm = a % b;
      ov = (q > 64'sd2147483647) || (q < -64'sd2147483648);
    end
    e      = '0;
    e.ovf  = ov;
    e.trap = ov && mk;
    if (ov) begin
      e.cc = {ci[3], 1'b1, ci[1:0]};
    end else begin
      e.cc = {ci[3], 1'b0, q > 0, q < 0};
      e.wa = 1'b1;
      if (hm || od) begin
        e.da = q[31:0];
      end else begin
        e.da = rm[31:0];
        e.wb = 1'b1;
        e.db = q[31:0];
      end
    end
    return e;
  endfunction

  // Starts an operation at the current (falling-edge) time and checks its result.
  task automatic run_op(input bit hm, input bit od, input logic [31:0] ra,
                        input logic [31:0] rb, input logic [31:0] dv,
                        input logic [3:0] ci, input bit mk, input string req,
                        input bit poke, input bit chain);
    exp_t e;
    int   cycles;
    bit   got;
    int   lat;
    e = model(hm, od, ra, rb, dv, ci, mk);
    lat = hm ? 33 : 65;
    half_mode = hm; odd_dst = od; reg_r = ra; reg_r1 = rb; divisor = dv;
    cc_in = ci; trap_mask = mk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    got = 1'b0;
    while (!got && cycles < 200) begin
      @(negedge clk);
      cycles++;
      if (done) got = 1'b1;
      else if (wr_r_en || wr_r1_en)
        check(1'b0, "R8", "write strobe before done", 1, 0);
      if (poke && cycles == 5) begin  // R9: disturbance while busy
        start = 1'b1; reg_r = ~ra; reg_r1 = ~rb; divisor = dv + 32'd3;
        half_mode = ~hm; cc_in = ~ci; trap_mask = ~mk;
      end
      if (poke && cycles == 6) start = 1'b0;
    end
    check(got && cycles == lat, "R8", "done latency", cycles, lat);
    check(wr_r_en == e.wa, req, "wr_r_en", wr_r_en, e.wa);
    if (e.wa) check(wr_r_data == e.da, req, "wr_r_data", wr_r_data, e.da);
    check(wr_r1_en == e.wb, req, "wr_r1_en", wr_r1_en, e.wb);
    if (e.wb) check(wr_r1_data == e.db, req, "wr_r1_data", wr_r1_data, e.db);
    check(cc_out == e.cc, e.ovf ? "R5" : "R6", "cc_out", cc_out, e.cc);
    check(trap_req == e.trap, "R7", "trap_req", trap_req, e.trap);
    if (e.trap) check(trap_vec == 8'h43, "R7", "trap_vec", trap_vec, 8'h43);
    if (!chain) begin
      @(negedge clk);
      check(!done, "R8", "done single cycle", done, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d64;
    logic [31:0] dv;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check(!done && !wr_r_en && !wr_r1_en && !trap_req, "R1", "idle outputs",
            {done, wr_r_en, wr_r1_en, trap_req}, 0);
    end

    // R2 directed: sign combinations, truncation toward zero
    run_op(0, 0, 32'h0, 32'd100, 32'd7, 4'b1000, 1, "R2", 0, 0);
    run_op(0, 0, 32'hFFFF_FFFF, -32'sd100, 32'd7, 4'b0000, 1, "R2", 0, 0);
    run_op(0, 0, 32'h0, 32'd100, -32'sd7, 4'b1011, 0, "R2", 0, 0);
    run_op(0, 0, 32'h0000_0001, 32'h0, 32'd2, 4'b0000, 0, "R2", 0, 0);
    // quotient exactly -2^31 is representable
    run_op(0, 0, 32'hFFFF_FFFE, 32'h8000_0000, 32'd3, 4'b0000, 1, "R2", 0, 0);
    // R5: most negative dividend by -1, quotient 2^31, divide by zero
    run_op(0, 0, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 4'b1011, 1, "R5", 0, 0);
    run_op(0, 0, 32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 4'b0010, 1, "R5", 0, 0);
    run_op(0, 0, 32'h0, 32'h8000_0000, 32'd1, 4'b1001, 0, "R5", 0, 0);
    run_op(0, 0, 32'h0, 32'd55, 32'd0, 4'b0001, 1, "R7", 0, 0);
    run_op(0, 0, 32'h0, 32'd55, 32'd0, 4'b1010, 0, "R7", 0, 0);
    // R3 odd destination
    run_op(0, 1, -32'sd7, 32'hDEAD_BEEF, 32'd2, 4'b0000, 0, "R3", 0, 0);
    run_op(0, 1, 32'h8000_0000, 32'h1234_5678, 32'hFFFF_FFFF, 4'b1000, 1, "R3", 0, 0);
    // R4 halfword: upper divisor bits and reg_r1 must not matter
    run_op(1, 0, 32'd1000, 32'hCAFE_F00D, 32'h1234_FFF9, 4'b0000, 0, "R4", 0, 0);
    run_op(1, 1, 32'h8000_0000, 32'h0, 32'h0000_FFFF, 4'b1001, 1, "R4", 0, 0);
    run_op(1, 0, 32'd3, 32'h0, 32'h7777_0007, 4'b0011, 0, "R4", 0, 0);
    run_op(1, 0, 32'h7FFF_FFFF, 32'h0, 32'h0000_0001, 4'b0000, 0, "R4", 0, 0);
    // R9: busy disturbance, then back-to-back start in the done cycle
    run_op(0, 0, 32'h0, 32'd1234567, 32'd89, 4'b0000, 0, "R9", 1, 0);
    run_op(1, 0, -32'sd9999, 32'h0, 32'h0000_0011, 4'b1000, 0, "R9", 1, 0);
    run_op(0, 0, 32'h0000_0003, 32'h1111_1111, 32'd77, 4'b0000, 0, "R9", 0, 1);
    run_op(1, 0, 32'd500, 32'h0, 32'h0000_FFFB, 4'b0000, 1, "R9", 0, 1);
    run_op(0, 1, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 4'b0000, 1, "R9", 0, 0);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      bit hm, od;
      hm  = ($urandom % 3) == 0;
      od  = ($urandom % 4) == 0;
      d64 = {$urandom, $urandom};
      d64 = $signed(d64) >>> ($urandom % 64);
      dv  = $urandom;
      dv  = $signed(dv) >>> ($urandom % 32);
      if (($urandom % 40) == 0) dv = '0;
      run_op(hm, od, d64[63:32], d64[31:0], dv, 4'($urandom), 1'($urandom),
             hm ? "R4" : (od ? "R3" : "R2"), 0, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule